// File: doc/BRIEF.md
# Linked-Descriptor Transmit Packet DMA Channel

This block is one transmit DMA channel. It walks a chain of buffer descriptors held in system memory and plays each buffer out as a byte stream. Each descriptor is four 32-bit words at consecutive addresses. Word 0 is the link to the next descriptor. Word 1 is the buffer address. Word 2 is the buffer byte count. Word 3 is the control/status word. Software writes the address of the first descriptor into the head register. The engine then fetches the descriptor, reads the buffer one word at a time, and sends its bytes on the stream port. It writes the control/status word back, with the hand-off flag cleared, and then moves on along the link.

A link of zero marks the last descriptor. The engine flags end-of-chain in that descriptor's status word, clears the head register and stops. Software must write the head register again to send more. A completion register lets software record the last descriptor it has retired. A self-clearing reset bit returns the channel to its start state. A stop request makes the engine halt at the next packet boundary and then report that it is quiescent.

Top module: `pktdma_tx_chan`

## Requirements
- R1: After reset the head, completion, reset, command and status registers (word indices 0, 1, 2, 3, 4) read zero, `mem_req` is low and `tx_valid` is low.
- R2: Writing a nonzero value to the head register while the engine is stopped starts a fetch. The four descriptor words are read at that address, then +4, +8 and +12, in that order.
- R3: The engine reads the buffer from the address in word 1, in whole 32-bit words. It sends exactly as many bytes as the low 11 bits of word 2, least significant byte of each word first.
- R4: A packet is one or more descriptors, from one with status bit 31 (start) set up to one with bit 30 (end) set. A packet shorter than 60 bytes is extended with zero bytes to 60. `tx_last` is high on exactly the final byte of each packet, padding included.
- R5: After its data has left, each descriptor's status word is rewritten at its address +12. Bit 29 (hand-off) is cleared. Bit 28 (end-of-chain) is set when the link word is zero and cleared otherwise. All other bits are kept.
- R6: After a writeback with a nonzero link, the head register reads the link value and processing goes on at that address. After a writeback with a zero link, the head register reads zero and the engine stops.
- R7: A fetched descriptor with bit 29 clear is not processed. No bytes are sent, no writeback is made, the head register is cleared and the engine stops.
- R8: A head-register write while the engine is busy is ignored. The head value and the chain being processed are unchanged.
- R9: The completion register (index 1) reads back the last value written to it and has no effect on the engine.
- R10: Writing 1 to bit 0 of the reset register (index 2) makes that bit read 1 for one cycle and then 0. The head, completion and command registers are cleared, and the engine and stream stop.
- R11: Setting bit 3 of the command register (index 3) makes the engine finish the current packet, including its writeback, and stop with the head register holding the next link. Status bit 31 (index 4) then reads 1. While bit 3 is set, head writes start nothing.
- R12: A start bit restarts the packet byte count, so padding and `tx_last` are judged over all descriptors of a multi-descriptor packet.
- R13: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of packet |
| tx_ready | input | 1 | Stream sink ready |

## Verification
The risky overlaps are a register command that lands in the very cycle the engine retires a descriptor. One case is a stop request racing the end-of-packet writeback. The other is a head write racing the writeback that loads the next link or clears the head. The bench gives random acknowledge and ready timing, so these edges fall at varying offsets from the register writes. It issues the stop request and the stray head writes while a chain is in flight. It judges the outcome from the head value read back, the status words left in memory and the exact byte stream received. A soft reset issued in the middle of a long buffer is judged the same way, at the ports.

// File: rtl/pktdma_pkg.sv
package pktdma_pkg;

  // status/control word flag positions
  localparam int FLG_START = 31;
  localparam int FLG_END   = 30;
  localparam int FLG_HAND  = 29;
  localparam int FLG_CHEND = 28;

  // register word indices
  localparam int RIX_HEAD  = 0;
  localparam int RIX_DONE  = 1;
  localparam int RIX_RESET = 2;
  localparam int RIX_CMD   = 3;
  localparam int RIX_STAT  = 4;

  localparam int CMD_STOP_BIT   = 3;
  localparam int STAT_QUIET_BIT = 31;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_FETCH,
    EN_RDBUF,
    EN_TAIL,
    EN_PAD,
    EN_WBACK
  } eng_state_t;

endpackage

// File: rtl/pktdma_regs.sv
module pktdma_regs
  import pktdma_pkg::*;
#(
  parameter int RA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            eng_busy,
  input  logic            head_clr,
  input  logic            head_load,
  input  logic [31:0]     head_load_val,
  output logic            start,
  output logic            stop_req,
  output logic            chan_clr,
  output logic            quiet
);

  logic [31:0] head_q, head_d;
  logic [31:0] done_q, done_d;
  logic        stop_q, stop_d;
  logic        srst_q, srst_d;
  logic        wr_head, wr_done, wr_reset, wr_cmd;

  always_comb begin
    wr_head  = reg_wr && (reg_addr == RA_W'(RIX_HEAD));
    wr_done  = reg_wr && (reg_addr == RA_W'(RIX_DONE));
    wr_reset = reg_wr && (reg_addr == RA_W'(RIX_RESET));
    wr_cmd   = reg_wr && (reg_addr == RA_W'(RIX_CMD));

    start = wr_head && !eng_busy && !srst_q && !stop_q && (reg_wdata != 32'd0);

    head_d = head_q;
    if (srst_q)                    head_d = 32'd0;
    else if (head_clr)             head_d = 32'd0;
    else if (head_load)            head_d = head_load_val;
    else if (wr_head && !eng_busy) head_d = reg_wdata;

    done_d = done_q;
    if (srst_q)       done_d = 32'd0;
    else if (wr_done) done_d = reg_wdata;

    stop_d = stop_q;
    if (srst_q)      stop_d = 1'b0;
    else if (wr_cmd) stop_d = reg_wdata[CMD_STOP_BIT];

    srst_d = srst_q;
    if (srst_q)        srst_d = 1'b0;
    else if (wr_reset) srst_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= 32'd0;
      done_q <= 32'd0;
      stop_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      head_q <= head_d;
      done_q <= done_d;
      stop_q <= stop_d;
      srst_q <= srst_d;
    end
  end

  always_comb begin
    chan_clr = srst_q;
    stop_req = stop_q;
    quiet    = stop_q && !eng_busy;
    reg_rdata = 32'd0;
    if (reg_addr == RA_W'(RIX_HEAD))       reg_rdata = head_q;
    else if (reg_addr == RA_W'(RIX_DONE))  reg_rdata = done_q;
    else if (reg_addr == RA_W'(RIX_RESET)) reg_rdata = {31'd0, srst_q};
    else if (reg_addr == RA_W'(RIX_CMD))   reg_rdata = 32'(stop_q) << CMD_STOP_BIT;
    else if (reg_addr == RA_W'(RIX_STAT))  reg_rdata = 32'(quiet) << STAT_QUIET_BIT;
  end

endmodule

// File: rtl/pktdma_ser.sv
module pktdma_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic [2:0]  load_cnt,
  input  logic        load_last,
  output logic        idle,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);

  logic [31:0] sh_q, sh_d;
  logic [2:0]  left_q, left_d;
  logic        last_q, last_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    last_d = last_q;
    if (load) begin
      sh_d   = load_word;
      left_d = load_cnt;
      last_d = load_last;
    end else if (tx_valid && tx_ready) begin
      sh_d   = {8'd0, sh_q[31:8]};
      left_d = left_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= 32'd0;
      left_q <= 3'd0;
      last_q <= 1'b0;
    end else if (clr) begin
      sh_q   <= 32'd0;
      left_q <= 3'd0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    idle     = (left_q == 3'd0);
    tx_valid = (left_q != 3'd0);
    tx_data  = sh_q[7:0];
    tx_last  = last_q && (left_q == 3'd1);
  end

endmodule

// File: rtl/pktdma_engine.sv
module pktdma_engine
  import pktdma_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 60,
  parameter int PKT_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic        stop_req,
  output logic        busy,
  output logic        head_clr,
  output logic        head_load,
  output logic [31:0] head_load_val,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        ser_idle,
  output logic        ser_load,
  output logic [31:0] ser_word,
  output logic [2:0]  ser_cnt,
  output logic        ser_last
);

  localparam logic [PKT_W-1:0] MINV = PKT_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] FOUR = LEN_W'(4);

  eng_state_t       st_q, st_d;
  logic [31:0]      cur_q, cur_d;
  logic [31:0]      nxt_q, nxt_d;
  logic [31:0]      buf_q, buf_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [31:0]      mode_q, mode_d;
  logic [1:0]       fix_q, fix_d;
  logic [PKT_W-1:0] pcnt_q, pcnt_d;

  logic [2:0]       chunk, pchunk;
  logic [PKT_W-1:0] pad_left;
  logic [31:0]      wb_word;

  always_comb begin
    chunk    = (rem_q > FOUR) ? 3'd4 : rem_q[2:0];
    pad_left = (pcnt_q < MINV) ? (MINV - pcnt_q) : '0;
    pchunk   = (pad_left > PKT_W'(4)) ? 3'd4 : pad_left[2:0];
    wb_word  = mode_q;
    wb_word[FLG_HAND]  = 1'b0;
    wb_word[FLG_CHEND] = (nxt_q == 32'd0);
  end

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    nxt_d  = nxt_q;
    buf_d  = buf_q;
    rem_d  = rem_q;
    mode_d = mode_q;
    fix_d  = fix_q;
    pcnt_d = pcnt_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_wdata = 32'd0;
    ser_load  = 1'b0;
    ser_word  = 32'd0;
    ser_cnt   = 3'd0;
    ser_last  = 1'b0;
    head_clr  = 1'b0;
    head_load = 1'b0;
    head_load_val = nxt_q;
    unique case (st_q)
      EN_IDLE: begin
        if (start) begin
          cur_d = start_addr;
          fix_d = 2'd0;
          st_d  = EN_FETCH;
        end
      end
      EN_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + 32'({fix_q, 2'b00});
        if (mem_ack) begin
          fix_d = fix_q + 2'd1;
          unique case (fix_q)
            2'd0: nxt_d = mem_rdata;
            2'd1: buf_d = mem_rdata;
            2'd2: rem_d = mem_rdata[LEN_W-1:0];
            default: begin
              mode_d = mem_rdata;
              if (!mem_rdata[FLG_HAND]) begin
                head_clr = 1'b1;
                st_d     = EN_IDLE;
              end else begin
                if (mem_rdata[FLG_START]) pcnt_d = '0;
                st_d = (rem_q == '0) ? EN_TAIL : EN_RDBUF;
              end
            end
          endcase
        end
      end
      EN_RDBUF: begin
        if (ser_idle) begin
          mem_req  = 1'b1;
          mem_addr = buf_q;
          if (mem_ack) begin
            ser_load = 1'b1;
            ser_word = mem_rdata;
            ser_cnt  = chunk;
            ser_last = mode_q[FLG_END] && (rem_q <= FOUR) &&
                       ((pcnt_q + PKT_W'(chunk)) >= MINV);
            buf_d  = buf_q + 32'd4;
            rem_d  = rem_q - LEN_W'(chunk);
            pcnt_d = pcnt_q + PKT_W'(chunk);
            if (rem_q <= FOUR) st_d = EN_TAIL;
          end
        end
      end
      EN_TAIL: begin
        st_d = (mode_q[FLG_END] && (pcnt_q < MINV)) ? EN_PAD : EN_WBACK;
      end
      EN_PAD: begin
        if (ser_idle) begin
          ser_load = 1'b1;
          ser_cnt  = pchunk;
          ser_last = (pad_left == PKT_W'(pchunk));
          pcnt_d   = pcnt_q + PKT_W'(pchunk);
          if (pad_left == PKT_W'(pchunk)) st_d = EN_WBACK;
        end
      end
      EN_WBACK: begin
        if (ser_idle) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = cur_q + 32'd12;
          mem_wdata = wb_word;
          if (mem_ack) begin
            if (nxt_q == 32'd0) begin
              head_clr = 1'b1;
              st_d     = EN_IDLE;
            end else begin
              head_load = 1'b1;
              if (stop_req && mode_q[FLG_END]) begin
                st_d = EN_IDLE;
              end else begin
                cur_d = nxt_q;
                fix_d = 2'd0;
                st_d  = EN_FETCH;
              end
            end
          end
        end
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      cur_q  <= 32'd0;
      nxt_q  <= 32'd0;
      buf_q  <= 32'd0;
      rem_q  <= '0;
      mode_q <= 32'd0;
      fix_q  <= 2'd0;
      pcnt_q <= '0;
    end else if (clr) begin
      st_q   <= EN_IDLE;
      cur_q  <= 32'd0;
      nxt_q  <= 32'd0;
      buf_q  <= 32'd0;
      rem_q  <= '0;
      mode_q <= 32'd0;
      fix_q  <= 2'd0;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      nxt_q  <= nxt_d;
      buf_q  <= buf_d;
      rem_q  <= rem_d;
      mode_q <= mode_d;
      fix_q  <= fix_d;
      pcnt_q <= pcnt_d;
    end
  end

  always_comb busy = (st_q != EN_IDLE);

endmodule

// File: rtl/pktdma_tx_chan.sv
module pktdma_tx_chan #(
  parameter int RA_W      = 3,
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  input  logic            tx_ready
);

  localparam int PKT_W = LEN_W + 5;

  logic        eng_busy, head_clr, head_load, start, stop_req, chan_clr, idle_flag;
  logic [31:0] head_load_val;
  logic        ser_idle, ser_load, ser_last;
  logic [31:0] ser_word;
  logic [2:0]  ser_cnt;

  pktdma_regs #(.RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .head_clr(head_clr), .head_load(head_load),
    .head_load_val(head_load_val), .start(start), .stop_req(stop_req),
    .chan_clr(chan_clr), .quiet(idle_flag)
  );

  pktdma_engine #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .PKT_W(PKT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(chan_clr),
    .start(start), .start_addr(reg_wdata), .stop_req(stop_req), .busy(eng_busy),
    .head_clr(head_clr), .head_load(head_load), .head_load_val(head_load_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ser_idle(ser_idle), .ser_load(ser_load), .ser_word(ser_word),
    .ser_cnt(ser_cnt), .ser_last(ser_last)
  );

  pktdma_ser u_ser (
    .clk(clk), .rst_n(rst_n), .clr(chan_clr),
    .load(ser_load), .load_word(ser_word), .load_cnt(ser_cnt), .load_last(ser_last),
    .idle(ser_idle), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready)
  );

endmodule

// File: rtl/pktdma_chk.sv
module pktdma_chk #(
  parameter int RA_W      = 3,
  parameter int MIN_FRAME = 60
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [RA_W-1:0] reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            mem_req,
  input logic            mem_we,
  input logic [31:0]     mem_addr,
  input logic [31:0]     mem_wdata,
  input logic            mem_ack,
  input logic            tx_valid,
  input logic [7:0]      tx_data,
  input logic            tx_last,
  input logic            tx_ready,
  input logic            idle_flag
);

  logic [15:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 16'd0;
    else if (tx_valid && tx_ready) begin
      if (tx_last)               bcnt <= 16'd0;
      else if (bcnt != 16'hFFFF) bcnt <= bcnt + 16'd1;
    end
  end

  assert_stream_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_min_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |-> (bcnt >= 16'(MIN_FRAME - 1)));

  assert_wback_hand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[29]);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> (!mem_req && !tx_valid));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_W'(2)) && reg_wdata[0]) |=> ##1
      (!mem_req && !tx_valid && !idle_flag));

endmodule

bind pktdma_tx_chan pktdma_chk #(.RA_W(RA_W), .MIN_FRAME(MIN_FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
  .tx_ready(tx_ready), .idle_flag(idle_flag)
);

// File: tb/pktdma_tx_chan_tb.sv
`timescale 1ns/1ps
module pktdma_tx_chan_tb;

  localparam logic [2:0] A_HEAD = 3'd0, A_DONE = 3'd1, A_RST = 3'd2, A_CMD = 3'd3, A_STAT = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  always #2.5 clk = ~clk;

  pktdma_tx_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int n_run = 0, n_fail = 0, hold_err = 0, cyc = 0;
  logic [31:0] mem [0:2047];
  logic [7:0]  rxq[$], expq[$];
  bit          rxl[$], expl[$];
  logic [31:0] rdlog[$];
  bit          pv_stall = 0, pm_wait = 0;
  logic [7:0]  pv_data = 8'd0;
  logic [31:0] pm_addr = 32'd0;

  // memory model and stream sink, acting between clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv_stall && (!tx_valid || tx_data != pv_data)) hold_err++;
      if (pm_wait && (!mem_req || mem_addr != pm_addr)) hold_err++;
      mem_ack = 1'b0;
      if (mem_req && ($urandom_range(0, 3) != 0)) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[12:2]] = mem_wdata;
        else begin
          mem_rdata = mem[mem_addr[12:2]];
          rdlog.push_back(mem_addr);
        end
      end
      tx_ready = ($urandom_range(0, 4) != 0);
      if (tx_valid && tx_ready) begin
        rxq.push_back(tx_data);
        rxl.push_back(tx_last);
      end
      pv_stall = tx_valid && !tx_ready;
      pv_data  = tx_data;
      pm_wait  = mem_req && !mem_ack;
      pm_addr  = mem_addr;
    end else begin
      mem_ack  = 1'b0;
      tx_ready = 1'b0;
      pv_stall = 0;
      pm_wait  = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_mode(bit s, bit e, bit o, logic [15:0] x, int len);
    return {s, e, o, 1'b0, 1'b0, x, 11'(len)};
  endfunction

  function automatic logic [31:0] mode_after(logic [31:0] orig, bit chain_end);
    logic [31:0] m = orig;
    m[29] = 1'b0;
    m[28] = chain_end;
    return m;
  endfunction

  task automatic put_desc(input int d, input int nx, input int bf, input int len,
                          input bit s, input bit e, input bit o, output logic [31:0] mode);
    mode = mk_mode(s, e, o, 16'($urandom()), len);
    mem[d >> 2]       = 32'(nx);
    mem[(d >> 2) + 1] = 32'(bf);
    mem[(d >> 2) + 2] = 32'(len);
    mem[(d >> 2) + 3] = mode;
    for (int w = 0; w < (len + 3) / 4; w++) mem[(bf >> 2) + w] = $urandom();
  endtask

  task automatic exp_bytes(input int bf, input int len);
    for (int i = 0; i < len; i++) begin
      logic [31:0] w = mem[(bf >> 2) + (i >> 2)];
      expq.push_back(w[8*(i%4) +: 8]);
      expl.push_back(1'b0);
    end
  endtask

  task automatic exp_close(input int total);
    for (int i = total; i < 60; i++) begin
      expq.push_back(8'd0);
      expl.push_back(1'b0);
    end
    expl[expl.size()-1] = 1'b1;
  endtask

  task automatic cmp_stream(input string rq);
    int bad = 0, badl = 0;
    chk(rxq.size() == expq.size(), rq, "stream length", rxq.size(), expq.size());
    for (int i = 0; i < rxq.size() && i < expq.size(); i++) begin
      if (rxq[i] != expq[i]) bad++;
      if (rxl[i] != expl[i]) badl++;
    end
    chk(bad == 0, rq, "byte mismatches", bad, 0);
    chk(badl == 0, "R4", "tx_last mismatches", badl, 0);
    rxq.delete(); rxl.delete(); expq.delete(); expl.delete();
  endtask

  task automatic wait_head_zero(input string rq);
    logic [31:0] v = 32'hFFFF_FFFF;
    for (int i = 0; i < 20000 && v != 0; i++) rd_reg(A_HEAD, v);
    repeat (4) @(negedge clk);
    chk(v == 0, rq, "head cleared at chain end", v, 0);
  endtask

  initial begin
    logic [31:0] v, m0, m1, m2, m3;
    int l0, l1, l2, l3;
    bit seen;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(A_HEAD, v); chk(v == 0, "R1", "head after reset", v, 0);
    rd_reg(A_DONE, v); chk(v == 0, "R1", "completion after reset", v, 0);
    rd_reg(A_RST, v);  chk(v == 0, "R1", "reset reg after reset", v, 0);
    rd_reg(A_CMD, v);  chk(v == 0, "R1", "command after reset", v, 0);
    rd_reg(A_STAT, v); chk(v == 0, "R1", "status after reset", v, 0);
    chk(!mem_req && !tx_valid, "R1", "bus idle after reset", {mem_req, tx_valid}, 0);

    // R2 R3 R5 single packet of 100 bytes
    put_desc('h100, 0, 'h800, 100, 1, 1, 1, m0);
    exp_bytes('h800, 100); exp_close(100);
    rdlog.delete();
    wr_reg(A_HEAD, 32'h100);
    wait_head_zero("R6");
    chk(rdlog.size() >= 4 && rdlog[0] == 'h100 && rdlog[1] == 'h104 &&
        rdlog[2] == 'h108 && rdlog[3] == 'h10C, "R2", "fetch order", rdlog[3], 'h10C);
    cmp_stream("R3");
    chk(mem['h10C >> 2] == mode_after(m0, 1), "R5", "status writeback",
        mem['h10C >> 2], mode_after(m0, 1));

    // R4 short packet padded to 60
    put_desc('h100, 0, 'h800, 5, 1, 1, 1, m0);
    exp_bytes('h800, 5); exp_close(5);
    wr_reg(A_HEAD, 32'h100);
    wait_head_zero("R6");
    cmp_stream("R4");

    // R6 R12 random chains including a split packet
    for (int it = 0; it < 3; it++) begin
      l0 = $urandom_range(1, 200); l1 = $urandom_range(1, 30);
      l2 = $urandom_range(1, 20);  l3 = $urandom_range(1, 200);
      put_desc('h600, 'h610, 'h800, l0, 1, 1, 1, m0);
      put_desc('h610, 'h620, 'h900, l1, 1, 0, 1, m1);
      put_desc('h620, 'h630, 'hA00, l2, 0, 1, 1, m2);
      put_desc('h630, 0,     'hB00, l3, 1, 1, 1, m3);
      exp_bytes('h800, l0); exp_close(l0);
      exp_bytes('h900, l1); exp_bytes('hA00, l2); exp_close(l1 + l2);
      exp_bytes('hB00, l3); exp_close(l3);
      wr_reg(A_HEAD, 32'h600);
      wait_head_zero("R6");
      cmp_stream("R12");
      chk(mem['h60C >> 2] == mode_after(m0, 0) && mem['h61C >> 2] == mode_after(m1, 0) &&
          mem['h62C >> 2] == mode_after(m2, 0), "R5", "mid-chain writebacks",
          mem['h61C >> 2], mode_after(m1, 0));
      chk(mem['h63C >> 2] == mode_after(m3, 1), "R6", "end-of-chain flag on last",
          mem['h63C >> 2], mode_after(m3, 1));
    end

    // R7 descriptor not handed to the engine
    put_desc('h200, 'h600, 'h800, 40, 1, 1, 0, m0);
    wr_reg(A_HEAD, 32'h200);
    repeat (60) @(negedge clk);
    rd_reg(A_HEAD, v);
    chk(v == 0, "R7", "head after refused descriptor", v, 0);
    chk(rxq.size() == 0, "R7", "bytes sent for refused descriptor", rxq.size(), 0);
    chk(mem['h20C >> 2] == m0, "R7", "status word untouched", mem['h20C >> 2], m0);

    // R8 head write while busy
    put_desc('h300, 0, 'h1000, 1500, 1, 1, 1, m0);
    exp_bytes('h1000, 1500); exp_close(1500);
    rdlog.delete();
    wr_reg(A_HEAD, 32'h300);
    repeat (20) @(negedge clk);
    wr_reg(A_HEAD, 32'h400);
    rd_reg(A_HEAD, v);
    chk(v == 'h300, "R8", "head after write while busy", v, 'h300);
    wait_head_zero("R8");
    seen = 0;
    foreach (rdlog[i]) if (rdlog[i] == 'h400) seen = 1;
    chk(!seen, "R8", "ignored address fetched", seen, 0);
    cmp_stream("R8");

    // R9 completion register
    wr_reg(A_DONE, 32'h300);
    rd_reg(A_DONE, v);
    chk(v == 'h300, "R9", "completion readback", v, 'h300);
    repeat (10) @(negedge clk);
    chk(!mem_req && !tx_valid, "R9", "engine quiet after completion write",
        {mem_req, tx_valid}, 0);

    // R11 stop request during a chain
    put_desc('h500, 'h520, 'h800, 80, 1, 1, 1, m0);
    put_desc('h520, 0,     'h900, 40, 1, 1, 1, m1);
    exp_bytes('h800, 80); exp_close(80);
    wr_reg(A_HEAD, 32'h500);
    wr_reg(A_CMD, 32'h8);
    v = 0;
    for (int i = 0; i < 5000 && !v[31]; i++) rd_reg(A_STAT, v);
    chk(v[31], "R11", "quiet status", v, 32'h8000_0000);
    rd_reg(A_HEAD, v);
    chk(v == 'h520, "R11", "head holds next link", v, 'h520);
    chk(mem['h50C >> 2] == mode_after(m0, 0), "R11", "first packet written back",
        mem['h50C >> 2], mode_after(m0, 0));
    chk(mem['h52C >> 2] == m1, "R11", "second descriptor untouched", mem['h52C >> 2], m1);
    cmp_stream("R11");
    wr_reg(A_HEAD, 32'h520);
    repeat (30) @(negedge clk);
    chk(!mem_req && rxq.size() == 0, "R11", "head write while stopped", rxq.size(), 0);
    wr_reg(A_CMD, 32'h0);
    rd_reg(A_STAT, v);
    chk(v == 0, "R11", "status after command cleared", v, 0);
    exp_bytes('h900, 40); exp_close(40);
    wr_reg(A_HEAD, 32'h520);
    wait_head_zero("R11");
    cmp_stream("R11");

    // R10 soft reset in the middle of a long buffer
    put_desc('h300, 0, 'h1000, 1500, 1, 1, 1, m0);
    wr_reg(A_HEAD, 32'h300);
    repeat (40) @(negedge clk);
    wr_reg(A_CMD, 32'h8);
    repeat (5) @(negedge clk);
    wr_reg(A_RST, 32'h1);
    rd_reg(A_RST, v); chk(v == 1, "R10", "reset bit visible", v, 1);
    rd_reg(A_RST, v); chk(v == 0, "R10", "reset bit self-cleared", v, 0);
    rd_reg(A_HEAD, v); chk(v == 0, "R10", "head cleared", v, 0);
    rd_reg(A_DONE, v); chk(v == 0, "R10", "completion cleared", v, 0);
    rd_reg(A_CMD, v);  chk(v == 0, "R10", "command cleared", v, 0);
    repeat (20) @(negedge clk);
    chk(!mem_req && !tx_valid, "R10", "engine stopped", {mem_req, tx_valid}, 0);
    rxq.delete(); rxl.delete();

    chk(hold_err == 0, "R13", "handshake hold violations", hold_err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule